// File: doc/BRIEF.md
# Message Padding Stage for a 512-bit Hash Core

This stage accepts a message as a stream of 32-bit words and hands the hash core complete 512-bit blocks. Data blocks pass through unchanged as soon as sixteen words have been collected. When software raises the digest command, the stage closes the message. It trims the final word to the number of valid bits supplied with the command and places a single one bit directly above the last valid bit. It then fills the rest of the block with zeros and writes the 64-bit message length into the top two word slots of the last block. If the marker leaves no room for the length field, a second block carrying only padding and the length follows.

Message bits fill each 32-bit word from bit 0 upward, so a word with a partial count `n` keeps bits `[n-1:0]`. Word `k` of a block (k = 0..15) occupies `blk_data[511-32k -: 32]`. The length counter runs across all blocks of a message. It restarts from zero once the final block has been taken, so back-to-back messages need no clearing step. The algorithm input chooses the word order of the length field.

Top module: `hp_pad_unit`

## Requirements
- R1: After reset `in_ready` is 1 and `blk_valid` is 0.
- R2: Sixteen accepted words without a digest command produce one block holding them in arrival order (word k in `blk_data[511-32k -: 32]`) with `blk_last` 0. `in_ready` stays 0 while any block is offered.
- R3: A nonzero `last_bits` value n (1..31) keeps bits `[n-1:0]` of the final word, clears the bits above, and sets bit n as the marker.
- R4: A `last_bits` value of 0 keeps the final word whole. The marker is then the next word slot, holding 32'h0000_0001.
- R5: The length field carries the message length in bits. It holds 32 bits per full word plus n for a partial final word. With `alg_md5`=0, word 14 holds length[63:32] and word 15 holds length[31:0]. With `alg_md5`=1 the two words swap.
- R6: When the marker lands in word 13 or lower, one final block is emitted: words after the marker are zero up to the length field, and `blk_last` is 1.
- R7: When the marker would land in word 14, word 15, or past word 15, two blocks follow. The first has `blk_last` 0 and zeros after the marker. The second has `blk_last` 1 and is zero apart from the length field and, in the past-word-15 case, the marker word 32'h0000_0001 in word 0.
- R8: A digest command with no word collected in the current block ignores `last_bits`. The block is then marker word 32'h0000_0001 in word 0, zeros, and the length.
- R9: A word accepted in the same cycle as the digest command is the final word of the message.
- R10: An offered block keeps `blk_data` and `blk_last` unchanged until `blk_ready` takes it.
- R11: After the final block is taken, `in_ready` returns to 1 and the next message's length starts from zero.
- R12: A digest command given while a block is offered has no effect: no padding block follows that block.
- R13: The length field counts the words of every earlier block of the same message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Message word offered |
| in_ready | output | 1 | Stage accepts a word this cycle |
| in_data | input | 32 | Message word |
| last_bits | input | 5 | Valid bits in final word, 0 meaning all 32 |
| calc_go | input | 1 | Digest command: close the message |
| alg_md5 | input | 1 | Length field word order: 0 high word first, 1 low word first |
| blk_valid | output | 1 | Block offered to the core |
| blk_ready | input | 1 | Core takes the offered block |
| blk_data | output | 512 | Block contents |
| blk_last | output | 1 | Offered block is the last of the message |

## Verification
The two functions that can fall in the same cycle are the acceptance of a message word and the digest command. The bench provokes this by driving the final word and `calc_go` on the same clock edge. It does so once with the word filling slot 15 under a partial count and once under a full count, and once on a later block of a three-block message. Each case is judged by the complete block images. The coinciding word must appear masked and marked, never as a separate data block. The length must include that word. The full-count slot-15 case must move the marker into word 0 of a second block.

// File: rtl/hp_pkg.sv
package hp_pkg;

  localparam int unsigned HP_WORD_W = 32;
  localparam int unsigned HP_CNT_W  = $clog2(HP_WORD_W);

  // FILL: collecting words; DATA: full data block offered;
  // PAD_A: padded block offered with one more to come; PAD_B: final block offered
  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_DATA  = 2'd1,
    ST_PAD_A = 2'd2,
    ST_PAD_B = 2'd3
  } hp_state_e;

  // keep bits below n, put the marker at bit n (n nonzero)
  function automatic logic [HP_WORD_W-1:0] hp_close_word(
    input logic [HP_WORD_W-1:0] w,
    input logic [HP_CNT_W-1:0]  n
  );
    logic [HP_WORD_W-1:0] keep;
    keep = (HP_WORD_W'(1) << n) - HP_WORD_W'(1);
    return (w & keep) | (HP_WORD_W'(1) << n);
  endfunction

endpackage

// File: rtl/hp_len_ctr.sv
module hp_len_ctr #(
  parameter int unsigned LEN_W = 64,
  parameter int unsigned STEP  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             ld,
  input  logic [LEN_W-1:0] ld_val,
  output logic [LEN_W-1:0] cnt
);

  logic [LEN_W-1:0] cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | ld | inc;
    if (clr)      cnt_n = '0;
    else if (ld)  cnt_n = ld_val;
    else          cnt_n = cnt + LEN_W'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_n;
  end

endmodule

// File: rtl/hp_blk_buf.sv
module hp_blk_buf #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NWORDS = 16,
  localparam int unsigned IDX_W = $clog2(NWORDS + 1),
  localparam int unsigned BLK_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ld_en,
  input  logic [BLK_W-1:0]  ld_img,
  output logic [BLK_W-1:0]  img
);

  for (genvar gw = 0; gw < NWORDS; gw++) begin : g_word
    logic [WORD_W-1:0] q, d;
    logic              en;

    always_comb begin
      en = ld_en | (wr_en && (wr_idx == IDX_W'(gw)));
      d  = ld_en ? ld_img[BLK_W-1-WORD_W*gw -: WORD_W] : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign img[BLK_W-1-WORD_W*gw -: WORD_W] = q;
  end

endmodule

// File: rtl/hp_pad_ctl.sv
module hp_pad_ctl
  import hp_pkg::*;
#(
  parameter int unsigned NWORDS = 16,
  localparam int unsigned IDX_W = $clog2(NWORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             calc_go,
  input  logic             need_extra,
  input  logic             blk_ready,
  output logic             in_ready,
  output logic             acc,
  output logic             take,
  output logic [IDX_W-1:0] fill,
  output logic             buf_wr,
  output logic             ld_first,
  output logic             ld_second,
  output logic             cnt_clr,
  output logic             cnt_inc,
  output logic             blk_valid,
  output logic             blk_last
);

  hp_state_e        state, state_n;
  logic [IDX_W-1:0] fill_n;

  always_comb begin
    in_ready  = (state == ST_FILL);
    acc       = in_valid && in_ready;
    take      = calc_go && in_ready;
    buf_wr    = acc && !take;
    cnt_inc   = acc && !take;
    ld_first  = take;
    ld_second = (state == ST_PAD_A) && blk_ready;
    cnt_clr   = (state == ST_PAD_B) && blk_ready;
    blk_valid = (state != ST_FILL);
    blk_last  = (state == ST_PAD_B);
  end

  always_comb begin
    state_n = state;
    fill_n  = fill;
    unique case (state)
      ST_FILL: begin
        if (take) begin
          state_n = need_extra ? ST_PAD_A : ST_PAD_B;
          fill_n  = '0;
        end else if (acc) begin
          if (fill == IDX_W'(NWORDS - 1)) begin
            state_n = ST_DATA;
            fill_n  = '0;
          end else begin
            fill_n = fill + IDX_W'(1);
          end
        end
      end
      ST_DATA:  if (blk_ready) state_n = ST_FILL;
      ST_PAD_A: if (blk_ready) state_n = ST_PAD_B;
      ST_PAD_B: if (blk_ready) state_n = ST_FILL;
      default:  state_n = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FILL;
      fill  <= '0;
    end else begin
      state <= state_n;
      fill  <= fill_n;
    end
  end

endmodule

// File: rtl/hp_pad_unit.sv
module hp_pad_unit
  import hp_pkg::*;
#(
  parameter int unsigned BLK_W = 512,
  parameter int unsigned LEN_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [HP_WORD_W-1:0] in_data,
  input  logic [HP_CNT_W-1:0]  last_bits,
  input  logic                 calc_go,
  input  logic                 alg_md5,
  output logic                 blk_valid,
  input  logic                 blk_ready,
  output logic [BLK_W-1:0]     blk_data,
  output logic                 blk_last
);

  localparam int unsigned WORD_W        = HP_WORD_W;
  localparam int unsigned NWORDS        = BLK_W / WORD_W;
  localparam int unsigned IDX_W         = $clog2(NWORDS + 1);
  localparam int unsigned LEN_WORDS     = LEN_W / WORD_W;
  localparam int unsigned LEN_BASE      = NWORDS - LEN_WORDS;
  localparam int unsigned LAST_DATA_IDX = LEN_BASE - 1;

  logic             acc, take, buf_wr, ld_first, ld_second;
  logic             cnt_clr, cnt_inc, need_extra;
  logic [IDX_W-1:0] fill, words, mark_idx, prev_idx;
  logic [BLK_W-1:0] buf_img, img_first, img_second, ld_img;
  logic [LEN_W-1:0] len_q, len_fin;
  logic [WORD_W-1:0] last_word, mark_word;
  logic             partial;
  logic             alg_q, alg_n, wrap_q, wrap_n;

  function automatic logic [WORD_W-1:0] len_word(
    input logic [LEN_W-1:0] len,
    input logic             md5,
    input int unsigned      k
  );
    return md5 ? len[WORD_W*k +: WORD_W] : len[LEN_W-1-WORD_W*k -: WORD_W];
  endfunction

  hp_pad_ctl #(.NWORDS(NWORDS)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .calc_go    (calc_go),
    .need_extra (need_extra),
    .blk_ready  (blk_ready),
    .in_ready   (in_ready),
    .acc        (acc),
    .take       (take),
    .fill       (fill),
    .buf_wr     (buf_wr),
    .ld_first   (ld_first),
    .ld_second  (ld_second),
    .cnt_clr    (cnt_clr),
    .cnt_inc    (cnt_inc),
    .blk_valid  (blk_valid),
    .blk_last   (blk_last)
  );

  hp_len_ctr #(.LEN_W(LEN_W), .STEP(WORD_W)) u_len (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cnt_clr),
    .inc    (cnt_inc),
    .ld     (take),
    .ld_val (len_fin),
    .cnt    (len_q)
  );

  hp_blk_buf #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (buf_wr),
    .wr_idx  (fill),
    .wr_data (in_data),
    .ld_en   (ld_first | ld_second),
    .ld_img  (ld_img),
    .img     (buf_img)
  );

  // closing arithmetic for the digest command
  always_comb begin
    words     = fill + IDX_W'(acc);
    partial   = (last_bits != '0) && (words != '0);
    prev_idx  = (fill == '0) ? '0 : fill - IDX_W'(1);
    last_word = acc ? in_data : buf_img[BLK_W-1-WORD_W*int'(prev_idx) -: WORD_W];
    mark_idx  = partial ? words - IDX_W'(1) : words;
    mark_word = partial ? hp_close_word(last_word, last_bits) : WORD_W'(1);
    need_extra = mark_idx > IDX_W'(LAST_DATA_IDX);
    len_fin   = len_q
              + (acc ? LEN_W'(WORD_W) : LEN_W'(0))
              - (partial ? (LEN_W'(WORD_W) - LEN_W'(last_bits)) : LEN_W'(0));
  end

  // first block image: data, marker, zero fill, optional length
  always_comb begin
    logic [WORD_W-1:0] src_w, val_w;
    img_first = '0;
    for (int w = 0; w < NWORDS; w++) begin
      src_w = (acc && (w == int'(fill))) ? in_data : buf_img[BLK_W-1-WORD_W*w -: WORD_W];
      if (w < int'(mark_idx))       val_w = src_w;
      else if (w == int'(mark_idx)) val_w = mark_word;
      else                          val_w = '0;
      if (!need_extra && (w >= int'(LEN_BASE)))
        val_w = len_word(len_fin, alg_md5, w - LEN_BASE);
      img_first[BLK_W-1-WORD_W*w -: WORD_W] = val_w;
    end
  end

  // extra block image: optional wrapped marker, zeros, length
  always_comb begin
    logic [WORD_W-1:0] val_w;
    img_second = '0;
    for (int w = 0; w < NWORDS; w++) begin
      val_w = ((w == 0) && wrap_q) ? WORD_W'(1) : '0;
      if (w >= int'(LEN_BASE))
        val_w = len_word(len_q, alg_q, w - LEN_BASE);
      img_second[BLK_W-1-WORD_W*w -: WORD_W] = val_w;
    end
  end

  assign ld_img = ld_first ? img_first : img_second;

  always_comb begin
    alg_n  = take ? alg_md5 : alg_q;
    wrap_n = take ? (mark_idx == IDX_W'(NWORDS)) : wrap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alg_q  <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      alg_q  <= alg_n;
      wrap_q <= wrap_n;
    end
  end

  assign blk_data = buf_img;

endmodule

// File: rtl/hp_pad_chk.sv
module hp_pad_chk #(
  parameter int unsigned BLK_W = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             calc_go,
  input logic             blk_valid,
  input logic             blk_ready,
  input logic             blk_last,
  input logic [BLK_W-1:0] blk_data
);

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_data) && $stable(blk_last));

  a_r2_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> !in_ready);

  a_r8_go_yields_block: assert property (@(posedge clk) disable iff (!rst_n)
    calc_go && in_ready |=> blk_valid);

  a_r9_word_and_go: assert property (@(posedge clk) disable iff (!rst_n)
    calc_go && in_valid && in_ready |=> blk_valid && !in_ready);

  a_r11_resume_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_ready && blk_last |=> in_ready && !blk_valid);

endmodule

bind hp_pad_unit hp_pad_chk #(.BLK_W(BLK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .calc_go   (calc_go),
  .blk_valid (blk_valid),
  .blk_ready (blk_ready),
  .blk_last  (blk_last),
  .blk_data  (blk_data)
);

// File: tb/tb_hp_pad_unit.sv
`timescale 1ns/1ps
module tb_hp_pad_unit;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, calc_go, alg_md5, blk_valid, blk_ready, blk_last;
  logic [31:0]  in_data;
  logic [4:0]   last_bits;
  logic [511:0] blk_data;

  int n_run  = 0;
  int n_fail = 0;

  logic [31:0] msg [64];
  logic [31:0] ex  [32];

  always #4 clk = ~clk;

  hp_pad_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .last_bits(last_bits), .calc_go(calc_go), .alg_md5(alg_md5),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data), .blk_last(blk_last)
  );

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] pack_msg(input int base);
    logic [511:0] r;
    for (int k = 0; k < 16; k++) r[511-32*k -: 32] = msg[base+k];
    return r;
  endfunction

  function automatic logic [511:0] pack_ex(input int base);
    logic [511:0] r;
    for (int k = 0; k < 16; k++) r[511-32*k -: 32] = ex[base+k];
    return r;
  endfunction

  task automatic push(input logic [31:0] d, input bit go);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; calc_go = go;
    @(negedge clk);
    in_valid = 1'b0; calc_go = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk);
    calc_go = 1'b1;
    @(negedge clk);
    calc_go = 1'b0;
  endtask

  task automatic take_block(input logic [511:0] exp, input bit exp_last, input string tag, input int stall);
    int waited = 0;
    while (!blk_valid && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    chk(blk_valid === 1'b1, {tag, " block offered"}, 512'(blk_valid), 512'(1));
    chk(blk_data === exp, {tag, " block data"}, blk_data, exp);
    chk(blk_last === exp_last, {tag, " last flag"}, 512'(blk_last), 512'(exp_last));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(blk_valid === 1'b1 && blk_data === exp, "R10 held while stalled", blk_data, exp);
    end
    blk_ready = 1'b1;
    @(negedge clk);
    blk_ready = 1'b0;
  endtask

  // whole message: nw words, count n, coincident command when co
  task automatic run_msg(input int nw, input int n, input bit md5, input bit co,
                         input string tag, input int stall);
    int     nfull, fb, mi;
    bit     part, two;
    longint bits;
    for (int i = 0; i < nw; i++) msg[i] = 32'h9E37_79B9 * (i + 1) + 32'h0F1E_2D3C * nw + n;
    nfull = co ? (nw - 1) / 16 : nw / 16;
    fb    = nw - 16 * nfull;
    last_bits = 5'(n);
    alg_md5   = md5;
    for (int i = 0; i < nw; i++) begin
      push(msg[i], co && (i == nw - 1));
      if (((i + 1) % 16 == 0) && ((i + 1) / 16 <= nfull))
        take_block(pack_msg(i - 15), 1'b0, "R2 R13 data", 0);
    end
    if (!co) pulse_go();
    part = (n != 0) && (fb != 0);
    bits = longint'(512 * nfull) + (part ? longint'(32 * (fb - 1) + n) : longint'(32 * fb));
    mi   = part ? fb - 1 : fb;
    for (int k = 0; k < 32; k++) ex[k] = 32'h0;
    for (int k = 0; k < mi; k++) ex[k] = msg[16 * nfull + k];
    ex[mi] = part ? ((msg[16 * nfull + mi] & ((32'h1 << n) - 32'h1)) | (32'h1 << n)) : 32'h1;
    two = mi > 13;
    ex[(two ? 16 : 0) + 14] = md5 ? bits[31:0]  : bits[63:32];
    ex[(two ? 16 : 0) + 15] = md5 ? bits[63:32] : bits[31:0];
    if (two) begin
      take_block(pack_ex(0), 1'b0, {tag, " first of two"}, stall);
      take_block(pack_ex(16), 1'b1, {tag, " extra block"}, 0);
    end else begin
      take_block(pack_ex(0), 1'b1, {tag, " single final"}, stall);
    end
    @(negedge clk);
    chk(in_ready === 1'b1 && blk_valid === 1'b0, "R11 idle after final", 512'({in_ready, blk_valid}), 512'(2));
  endtask

  task automatic reset_check();
    chk(in_ready === 1'b1, "R1 in_ready after reset", 512'(in_ready), 512'(1));
    chk(blk_valid === 1'b0, "R1 blk_valid after reset", 512'(blk_valid), 512'(0));
  endtask

  // command while a data block waits must not add a padding block
  task automatic go_while_pending();
    last_bits = 5'd9; alg_md5 = 1'b0;
    for (int i = 0; i < 16; i++) begin
      msg[i] = 32'hC001_0000 + i;
      push(msg[i], 1'b0);
    end
    pulse_go();
    take_block(pack_msg(0), 1'b0, "R12 pending data", 0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(blk_valid === 1'b0 && in_ready === 1'b1, "R12 no padding block", 512'({blk_valid, in_ready}), 512'(1));
    end
    // close it now: empty buffer, count ignored, length 512
    last_bits = 5'd0;
    pulse_go();
    for (int k = 0; k < 16; k++) ex[k] = 32'h0;
    ex[0] = 32'h1; ex[15] = 32'd512;
    take_block(pack_ex(0), 1'b1, "R12 R8 close after", 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; calc_go = 1'b0;
    alg_md5 = 1'b0; blk_ready = 1'b0; last_bits = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_check();
    run_msg(3,  8,  1'b0, 1'b0, "R3 R5 R6 R10", 3);
    run_msg(5,  0,  1'b1, 1'b0, "R4 R5 R11", 0);
    run_msg(20, 0,  1'b0, 1'b0, "R13 R5", 0);
    run_msg(14, 5,  1'b0, 1'b0, "R6 R3 boundary", 0);
    run_msg(15, 0,  1'b1, 1'b0, "R7 R4", 0);
    run_msg(14, 0,  1'b0, 1'b0, "R7 slot14", 0);
    run_msg(16, 12, 1'b0, 1'b1, "R9 R7 partial", 0);
    run_msg(16, 0,  1'b1, 1'b1, "R9 R7 wrap", 2);
    run_msg(16, 7,  1'b0, 1'b0, "R8 empty", 0);
    go_while_pending();
    run_msg(35, 19, 1'b1, 1'b1, "R9 R13 R3", 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule